// File: doc/BRIEF.md
# Write-Enable and Block-Protect Status Controller

This block is the status and write-gating core of a serial EEPROM slave. A front end that shifts the serial bus tells it when an instruction byte is complete, when each later byte is complete, and when chip select rises cleanly on a byte boundary. From these strobes the block keeps the write-enable latch, the two block-protect bits and the protect-enable bit. It decides whether an array write or a status write may begin. When one may, it runs a counter that stands in for the self-timed programming time.

The status byte is driven at all times, so the front end can shift it out for a status-read instruction even while a write cycle is in progress. A one-cycle permit pulse tells the storage side to commit its page buffer. The busy output tells the read path to refuse array reads. The length of the programming interval is the parameter `WR_CYCLES`, counted in clock cycles.

Top module: `wprot_status_ctl`

## Requirements
- R1: After a synchronous reset the status byte is 0x00, busy is 0 and the write permit is 0.
- R2: Status byte layout: bit 0 is the write-in-progress flag (equal to busy), bit 1 is the write-enable latch, bit 2 is protect bit 0, bit 3 is protect bit 1 and bit 7 is protect-enable. Bits 6 to 4 read 0.
- R3: Opcode 0x06 sets the write-enable latch only if chip select rises on the boundary directly after that opcode byte. If any further byte completes first, the latch is left unchanged.
- R4: Opcode 0x04 clears the write-enable latch in the cycle after its opcode strobe.
- R5: Opcode 0x01 followed by at least one byte and a boundary rise, with the latch set, starts a write cycle. The first following byte supplies protect-enable (bit 7) and the two protect bits (bits 3:2). The attempt is refused when protect-enable is 1 and the write-protect pin is low: then no cycle starts, the protect bits are kept and the latch is cleared.
- R6: Opcode 0x02 followed by at least three bytes (two address bytes and data) and a boundary rise pulses the write permit for one cycle and starts a write cycle. This happens only if the latch is set and the target address is not protected. A refused or short attempt starts nothing and leaves the latch as it was.
- R7: Protect bits 00 protect nothing, 01 protect addresses 6000h to 7FFFh, 10 protect 4000h to 7FFFh, and 11 protect the whole array.
- R8: Busy rises in the cycle after the accepted boundary rise and stays high for exactly `WR_CYCLES` cycles.
- R9: When the write cycle ends, the write-enable latch is cleared.
- R10: While busy, every opcode and every request is ignored, and the status byte stays readable. Opcodes other than 0x01, 0x02, 0x04 and 0x06 never change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opc_stb_i | input | 1 | Instruction byte completed this cycle |
| opc_i | input | 8 | Instruction byte value |
| byte_stb_i | input | 1 | A byte after the instruction completed this cycle |
| byte_i | input | 8 | Value of that byte |
| cs_end_i | input | 1 | Chip select rose on a byte boundary |
| addr_i | input | AW | Target array address of the current write |
| wp_n_i | input | 1 | Write-protect pin, low means protect |
| status_o | output | 8 | Status byte |
| wr_go_o | output | 1 | One-cycle permit to commit an array write |
| busy_o | output | 1 | Write cycle in progress |

## Verification
The bench targets the following corner cases and the wrong behaviour each one would expose:
- The enable opcode followed by an extra byte before chip select rises. A design that arms on the opcode alone would later accept writes it should refuse.
- The addresses just inside and just outside each protected fraction. An off-by-one range compare would let a write through into the protected area, or lock out the byte just below it.
- A status write with protect-enable set and the pin low. A design that skips this case would let the protection be changed freely.
- Disable and status-write opcodes issued during a busy interval. A design that does not gate on busy would drop the latch or change the protect bits in mid-cycle.
- The exact length of the busy window and the clearing of the latch at its end.

// File: rtl/wps_pkg.sv
package wps_pkg;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_WRSR  = 8'h01;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam int SR_WIP  = 0;
  localparam int SR_WEL  = 1;
  localparam int SR_BP0  = 2;
  localparam int SR_BP1  = 3;
  localparam int SR_WPEN = 7;
  localparam int ARR_MIN_BYTES = 3;
endpackage

// File: rtl/wps_cmd_track.sv
module wps_cmd_track
  import wps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       opc_stb_i,
  input  logic [7:0] opc_i,
  input  logic       byte_stb_i,
  input  logic [7:0] byte_i,
  input  logic       cs_end_i,
  output logic       wren_done_o,
  output logic       wrdi_o,
  output logic       sr_req_o,
  output logic       arr_req_o,
  output logic [7:0] sr_byte_o
);
  logic [7:0] op_q;
  logic [1:0] nb_q;
  logic       armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q      <= 8'h00;
      nb_q      <= 2'd0;
      armed_q   <= 1'b0;
      sr_byte_o <= 8'h00;
    end else if (opc_stb_i) begin
      op_q    <= opc_i;
      nb_q    <= 2'd0;
      armed_q <= 1'b1;
    end else begin
      if (byte_stb_i && armed_q) begin
        if (nb_q == 2'd0) sr_byte_o <= byte_i;
        if (nb_q != 2'd3) nb_q <= nb_q + 2'd1;
      end
      if (cs_end_i) armed_q <= 1'b0;
    end
  end

  assign wrdi_o      = opc_stb_i && (opc_i == OPC_WRDI);
  assign wren_done_o = cs_end_i && armed_q && (op_q == OPC_WREN) && (nb_q == 2'd0);
  assign sr_req_o    = cs_end_i && armed_q && (op_q == OPC_WRSR) && (nb_q != 2'd0);
  assign arr_req_o   = cs_end_i && armed_q && (op_q == OPC_WRITE) &&
                       (nb_q >= 2'(ARR_MIN_BYTES));

  a_r3_wren_needs_clean_end: assert property (@(posedge clk) disable iff (rst)
    wren_done_o |-> !$past(byte_stb_i && !opc_stb_i));
endmodule

// File: rtl/wps_prot_range.sv
module wps_prot_range #(
  parameter int AW = 15
) (
  input  logic [1:0]    bp_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  localparam logic [AW-1:0] QTR_LO  = {2'b11, {(AW-2){1'b0}}};
  localparam logic [AW-1:0] HALF_LO = {1'b1, {(AW-1){1'b0}}};

  always_comb begin
    case (bp_i)
      2'b00:   hit_o = 1'b0;
      2'b01:   hit_o = (addr_i >= QTR_LO);
      2'b10:   hit_o = (addr_i >= HALF_LO);
      default: hit_o = 1'b1;
    endcase
  end

  always_comb begin
    if (bp_i == 2'b11) a_r7_all_hit: assert (hit_o);
  end
endmodule

// File: rtl/wps_wc_timer.sv
module wps_wc_timer #(
  parameter int CYCLES = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      cnt_q  <= LAST;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done_o = busy_o && (cnt_q == '0);

  a_r8_busy_ends: assert property (@(posedge clk) disable iff (rst)
    (busy_o && cnt_q == '0) |=> !busy_o);
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (cnt_q <= LAST));
  a_r8_load_full: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (cnt_q == LAST));
endmodule

// File: rtl/wprot_status_ctl.sv
module wprot_status_ctl
  import wps_pkg::*;
#(
  parameter int AW        = 15,
  parameter int WR_CYCLES = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          opc_stb_i,
  input  logic [7:0]    opc_i,
  input  logic          byte_stb_i,
  input  logic [7:0]    byte_i,
  input  logic          cs_end_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wp_n_i,
  output logic [7:0]    status_o,
  output logic          wr_go_o,
  output logic          busy_o
);
  logic       wren_done, wrdi, sr_req, arr_req, prot_hit, done;
  logic [7:0] sr_byte;
  logic       wel, wpen;
  logic [1:0] bp;
  logic       sr_lock, sr_ok, arr_ok, start;
  logic       unused_sr_bits;

  wps_cmd_track u_track (
    .clk(clk), .rst(rst), .opc_stb_i(opc_stb_i), .opc_i(opc_i),
    .byte_stb_i(byte_stb_i), .byte_i(byte_i), .cs_end_i(cs_end_i),
    .wren_done_o(wren_done), .wrdi_o(wrdi), .sr_req_o(sr_req),
    .arr_req_o(arr_req), .sr_byte_o(sr_byte)
  );

  wps_prot_range #(.AW(AW)) u_prot (
    .bp_i(bp), .addr_i(addr_i), .hit_o(prot_hit)
  );

  wps_wc_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start_i(start), .busy_o(busy_o), .done_o(done)
  );

  assign unused_sr_bits = ^{sr_byte[6:4], sr_byte[1:0]};

  assign sr_lock = wpen && !wp_n_i;
  assign sr_ok   = sr_req && wel && !busy_o && !sr_lock;
  assign arr_ok  = arr_req && wel && !busy_o && !prot_hit;
  assign start   = sr_ok || arr_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel     <= 1'b0;
      wpen    <= 1'b0;
      bp      <= 2'b00;
      wr_go_o <= 1'b0;
    end else begin
      wr_go_o <= arr_ok;
      if (done) begin
        wel <= 1'b0;
      end else if (!busy_o) begin
        if (wrdi)      wel <= 1'b0;
        if (wren_done) wel <= 1'b1;
        if (sr_req && wel && sr_lock) wel <= 1'b0;
        if (sr_ok) begin
          wpen <= sr_byte[SR_WPEN];
          bp   <= {sr_byte[SR_BP1], sr_byte[SR_BP0]};
        end
      end
    end
  end

  always_comb begin
    status_o          = 8'h00;
    status_o[SR_WIP]  = busy_o;
    status_o[SR_WEL]  = wel;
    status_o[SR_BP0]  = bp[0];
    status_o[SR_BP1]  = bp[1];
    status_o[SR_WPEN] = wpen;
  end

  a_r6_go_with_busy: assert property (@(posedge clk) disable iff (rst)
    wr_go_o |-> $rose(busy_o));
  a_r6_go_unprotected: assert property (@(posedge clk) disable iff (rst)
    wr_go_o |-> !$past(prot_hit));
  a_r9_done_clears_wel: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> !wel);
  a_r3_wel_source: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(wren_done));
  a_r5_bp_changes_on_start: assert property (@(posedge clk) disable iff (rst)
    !$stable(bp) |-> $rose(busy_o));
  a_r10_wel_held_busy: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o) && !$past(done)) |-> $stable(wel));
endmodule

// File: tb/wprot_status_ctl_tb.sv
module wprot_status_ctl_tb;
  localparam int AW = 15;
  localparam int W  = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          opc_stb_i = 1'b0, byte_stb_i = 1'b0, cs_end_i = 1'b0, wp_n_i = 1'b1;
  logic [7:0]    opc_i = 8'h00, byte_i = 8'h00;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    status_o;
  logic          wr_go_o, busy_o;

  int nchk = 0, nfail = 0;
  bit m_wel = 0, m_wpen = 0;
  logic [1:0] m_bp = 2'b00;

  always #2 clk = ~clk;

  wprot_status_ctl #(.AW(AW), .WR_CYCLES(W)) u_dut (
    .clk(clk), .rst(rst), .opc_stb_i(opc_stb_i), .opc_i(opc_i),
    .byte_stb_i(byte_stb_i), .byte_i(byte_i), .cs_end_i(cs_end_i),
    .addr_i(addr_i), .wp_n_i(wp_n_i), .status_o(status_o),
    .wr_go_o(wr_go_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sr(input bit busy);
    return {m_wpen, 3'b000, m_bp, m_wel, busy};
  endfunction

  function automatic bit prot(input logic [1:0] bp, input logic [AW-1:0] a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a >= 15'h6000;
      2'b10:   return a >= 15'h4000;
      default: return 1'b1;
    endcase
  endfunction

  task automatic p_op(input logic [7:0] o);
    @(negedge clk); opc_i = o; opc_stb_i = 1'b1;
    @(negedge clk); opc_stb_i = 1'b0;
  endtask

  task automatic p_byte(input logic [7:0] b);
    @(negedge clk); byte_i = b; byte_stb_i = 1'b1;
    @(negedge clk); byte_stb_i = 1'b0;
  endtask

  task automatic p_end();
    @(negedge clk); cs_end_i = 1'b1;
    @(negedge clk); cs_end_i = 1'b0;
  endtask

  task automatic wait_cycle(input string tag);
    int n = 1;
    for (int k = 0; k < W + 8; k++) begin
      @(negedge clk);
      if (busy_o) n++;
      else break;
    end
    chk(n == W, {tag, " R8 busy length"}, n, W);
    m_wel = 0;
    chk(status_o == exp_sr(0), {tag, " R9 latch cleared at end"}, status_o, exp_sr(0));
  endtask

  task automatic txn(input logic [7:0] op, input int nb, input logic [7:0] b0,
                     input logic [AW-1:0] a, input bit wp, input string tag);
    bit st, go;
    addr_i = a; wp_n_i = wp;
    p_op(op);
    if (op == 8'h04) begin
      m_wel = 0;
      chk(status_o == exp_sr(0), {tag, " R4 disable"}, status_o, exp_sr(0));
    end
    for (int k = 0; k < nb; k++) p_byte(k == 0 ? b0 : 8'($urandom));
    st = 0; go = 0;
    if (op == 8'h06 && nb == 0) m_wel = 1;
    else if (op == 8'h01 && nb >= 1 && m_wel) begin
      if (m_wpen && !wp) m_wel = 0;
      else begin st = 1; m_wpen = b0[7]; m_bp = b0[3:2]; end
    end else if (op == 8'h02 && nb >= 3 && m_wel && !prot(m_bp, a)) begin
      st = 1; go = 1;
    end
    p_end();
    chk(status_o == exp_sr(st), {tag, " R2 R3 R5 R7 status"}, status_o, exp_sr(st));
    chk(wr_go_o == go, {tag, " R6 permit"}, wr_go_o, go);
    if (st) wait_cycle(tag);
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(status_o == 8'h00 && !busy_o && !wr_go_o, "R1 reset state", status_o, 0);

    txn(8'h06, 1, 8'h00, 0, 1, "R3 extra byte");
    chk(status_o[1] == 1'b0, "R3 latch not set after extra byte", status_o[1], 0);
    txn(8'h06, 0, 8'h00, 0, 1, "R3 clean end");
    txn(8'h04, 0, 8'h00, 0, 1, "R4 disable");
    txn(8'h02, 3, 8'h11, 0, 1, "R6 no latch");
    txn(8'h06, 0, 8'h00, 0, 1, "R3");
    txn(8'h01, 1, 8'h8C, 0, 1, "R5 set all");
    txn(8'h06, 0, 8'h00, 0, 1, "R3");
    txn(8'h02, 3, 8'h55, 15'h0000, 1, "R7 all protected");
    txn(8'h01, 1, 8'h00, 0, 0, "R5 pin lock");
    txn(8'h06, 0, 8'h00, 0, 1, "R3");
    txn(8'h01, 1, 8'h04, 0, 1, "R5 quarter");
    txn(8'h06, 0, 8'h00, 0, 1, "R3");
    txn(8'h02, 3, 8'h01, 15'h6000, 1, "R7 quarter low edge");
    txn(8'h02, 4, 8'h01, 15'h5FFF, 1, "R7 below quarter");
    txn(8'h06, 0, 8'h00, 0, 1, "R3");
    txn(8'h01, 1, 8'h08, 0, 1, "R5 half");
    txn(8'h06, 0, 8'h00, 0, 1, "R3");
    txn(8'h02, 3, 8'h01, 15'h4000, 1, "R7 half low edge");
    txn(8'h02, 2, 8'h01, 15'h3FFF, 1, "R6 short write");
    txn(8'h05, 0, 8'h00, 0, 1, "R10 status read opcode");
    txn(8'h03, 3, 8'h00, 0, 1, "R10 read opcode");
    chk(status_o[1] == 1'b1, "R10 latch kept by other opcodes", status_o[1], 1);

    // busy window: disable and status write must be ignored
    addr_i = 15'h3FFF; wp_n_i = 1'b1;
    p_op(8'h02); p_byte(8'h00); p_byte(8'h00); p_byte(8'hA5); p_end();
    chk(busy_o && wr_go_o, "R6 write accepted below half", {busy_o, wr_go_o}, 3);
    p_op(8'h04);
    chk(status_o == exp_sr(1), "R10 disable ignored while busy", status_o, exp_sr(1));
    p_op(8'h01); p_byte(8'h0C); p_end();
    chk(status_o == exp_sr(1), "R10 status write ignored while busy", status_o, exp_sr(1));
    begin
      int n = 0;
      for (int k = 0; k < W + 8; k++) begin
        @(negedge clk);
        if (!busy_o) break;
        n++;
      end
      chk(!busy_o, "R8 busy ends", busy_o, 0);
    end
    m_wel = 0;
    chk(status_o == exp_sr(0), "R9 latch cleared after busy", status_o, exp_sr(0));

    for (int i = 0; i < 400; i++) begin
      logic [7:0] ops[6] = '{8'h06, 8'h04, 8'h02, 8'h01, 8'h05, 8'h03};
      logic [7:0] op = ops[$urandom_range(5)];
      int nb = (op == 8'h06 || op == 8'h04) ? (($urandom_range(3) == 0) ? 1 : 0)
                                           : $urandom_range(4);
      logic [7:0] b0 = 8'($urandom) & 8'hB3;
      if ($urandom_range(3) == 0) b0 = 8'($urandom);
      txn(op, nb, b0, AW'($urandom), 1'($urandom_range(3) != 0), "rand");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule